// File: doc/BRIEF.md
# Signed Magnitude Comparator Built on a Shared Subtractor

This block compares two signed two's complement operands of parameterizable width. It does not build a separate compare tree for each relation. It forms a single difference, A minus B. To do this it inverts every bit of B and feeds the result, with a carry-in of one, into a chain of full-adder stages. Each stage's carry-out drives the next stage's carry-in.

All four relation flags come from that one difference:

- **less-than** comes from the sign of the difference, corrected by the signed overflow of the subtraction.
- **equal** comes from a zero tester that NORs every bit of the difference.
- **greater-than** is asserted when the result is neither less nor equal.
- **not-equal** is the inverse of the zero tester.

The raw difference is also brought out so it can be observed. The block is purely combinational, with no clock and no reset. It sits inline in a datapath wherever a signed relation between two operands is needed.

Top module: `signed_sub_compare`

## Requirements
- R1: `diff_o` equals (`op_a` − `op_b`) modulo 2^WIDTH for every input pair. It is formed by adding `op_a` to the bitwise inverse of `op_b` with a carry-in of one.
- R2: `lt_o` is 1 exactly when `op_a` < `op_b` as signed values. It is the sign bit (bit WIDTH−1) of the difference XOR the signed overflow of the subtraction, so it stays correct when A − B overflows.
- R3: `eq_o` is 1 exactly when every bit of the difference is 0, which happens exactly when `op_a` equals `op_b`.
- R4: `gt_o` is 1 exactly when `op_a` > `op_b` as signed values. It is asserted only when neither `lt_o` nor `eq_o` is asserted.
- R5: `ne_o` is always the inverse of `eq_o`, and is 1 exactly when `op_a` differs from `op_b`.
- R6: Exactly one of `lt_o`, `eq_o` and `gt_o` is 1 for any input pair.
- R7: The width defaults to 8 bits. At that width, the extreme pairs behave as follows:
  - The most negative value against any larger value reports less-than.
  - The most positive value against any smaller value reports greater-than.
  - In both cases the difference wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First signed operand (minuend) |
| op_b | input | WIDTH | Second signed operand (subtrahend) |
| diff_o | output | WIDTH | Raw difference op_a − op_b, wrapped to WIDTH bits |
| lt_o | output | 1 | op_a is less than op_b (signed) |
| eq_o | output | 1 | op_a equals op_b |
| gt_o | output | 1 | op_a is greater than op_b (signed) |
| ne_o | output | 1 | op_a differs from op_b |

## Verification
At a width of 4 the bench tries all 256 operand pairs against a behavioural signed compare. That sweep separates three groups of cases:

- pairs whose subtraction overflows, where the raw sign bit alone would give the wrong less-than answer;
- equal pairs, which exercise the zero tester;
- ordinary pairs, which exercise the carry ripple across every stage.

At the default 8-bit width, directed pairs cover the extremes: most negative against one, most positive against the most negative, and zero against zero. These confirm that the wrap of the difference and the overflow correction also hold at full width.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic ne;
  } rel_flags_t;

endpackage

// File: rtl/sub_fa_cell.sv
module sub_fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic half_x;

  assign half_x = x_i ^ y_i;
  assign s_o    = half_x ^ c_i;
  assign c_o    = (x_i & y_i) | (half_x & c_i);

endmodule

// File: rtl/sub_ripple_adder.sv
module sub_ripple_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_top_in_o,
  output logic             c_out_o
);

  logic [WIDTH:0] chain;

  assign chain[0] = cin_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    sub_fa_cell u_cell (
      .x_i (x_i[k]),
      .y_i (y_i[k]),
      .c_i (chain[k]),
      .s_o (sum_o[k]),
      .c_o (chain[k+1])
    );
  end

  assign c_top_in_o = chain[WIDTH-1];
  assign c_out_o    = chain[WIDTH];

endmodule

// File: rtl/sub_zero_detect.sv
module sub_zero_detect #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);

  assign zero_o = ~(|val_i);

endmodule

// File: rtl/sub_rel_flags.sv
module sub_rel_flags
  import cmp_pkg::*;
(
  input  logic       sign_i,
  input  logic       ovf_i,
  input  logic       zero_i,
  output rel_flags_t flags_o
);

  logic less;

  assign less       = sign_i ^ ovf_i;
  assign flags_o.lt = less;
  assign flags_o.eq = zero_i;
  assign flags_o.gt = ~less & ~zero_i;
  assign flags_o.ne = ~zero_i;

endmodule

// File: rtl/signed_sub_compare.sv
module signed_sub_compare
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] diff_o,
  output logic             lt_o,
  output logic             eq_o,
  output logic             gt_o,
  output logic             ne_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_flip;
  logic [WIDTH-1:0] diff;
  logic             c_top_in;
  logic             c_out;
  logic             ovf;
  logic             zero;
  rel_flags_t       flags;

  // two's complement negate: invert here, the +1 enters as carry-in
  assign b_flip = ~op_b;

  sub_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .x_i        (op_a),
    .y_i        (b_flip),
    .cin_i      (1'b1),
    .sum_o      (diff),
    .c_top_in_o (c_top_in),
    .c_out_o    (c_out)
  );

  // signed overflow: carry into the top stage disagrees with carry out
  assign ovf = c_top_in ^ c_out;

  sub_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .val_i  (diff),
    .zero_o (zero)
  );

  sub_rel_flags u_flags (
    .sign_i  (diff[MSB]),
    .ovf_i   (ovf),
    .zero_i  (zero),
    .flags_o (flags)
  );

  assign diff_o = diff;
  assign lt_o   = flags.lt;
  assign eq_o   = flags.eq;
  assign gt_o   = flags.gt;
  assign ne_o   = flags.ne;

endmodule

// File: rtl/signed_sub_compare_chk.sv
module signed_sub_compare_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH-1:0] diff_o,
  input logic             lt_o,
  input logic             eq_o,
  input logic             gt_o,
  input logic             ne_o
);

  logic [WIDTH-1:0] ref_diff;

  always_comb begin
    ref_diff = op_a - op_b;
    assert_diff_R1: assert (diff_o == ref_diff)
      else $error("R1 difference mismatch");
    assert_lt_signed_R2: assert (lt_o == ($signed(op_a) < $signed(op_b)))
      else $error("R2 less-than mismatch");
    assert_eq_R3: assert (eq_o == (op_a == op_b))
      else $error("R3 equal mismatch");
    assert_gt_signed_R4: assert (gt_o == ($signed(op_a) > $signed(op_b)))
      else $error("R4 greater-than mismatch");
    assert_ne_R5: assert (ne_o == (op_a != op_b))
      else $error("R5 not-equal mismatch");
    assert_one_hot_R6: assert ($countones({lt_o, eq_o, gt_o}) == 1)
      else $error("R6 relation flags not one-hot");
  end

endmodule

bind signed_sub_compare signed_sub_compare_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a   (op_a),
  .op_b   (op_b),
  .diff_o (diff_o),
  .lt_o   (lt_o),
  .eq_o   (eq_o),
  .gt_o   (gt_o),
  .ne_o   (ne_o)
);

// File: tb/tb_signed_sub_compare.sv
module tb_signed_sub_compare;

  localparam int WATCHDOG = 20000;

  typedef struct {
    bit         wide;
    logic [7:0] diff;
    logic       lt;
    logic       eq;
    logic       gt;
    logic       ne;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0] a4 = '0, b4 = '0, d4;
  logic       lt4, eq4, gt4, ne4;
  logic [7:0] a8 = '0, b8 = '0, d8;
  logic       lt8, eq8, gt8, ne8;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  exp_t sb_q[$];

  signed_sub_compare #(.WIDTH(4)) dut (
    .op_a(a4), .op_b(b4), .diff_o(d4),
    .lt_o(lt4), .eq_o(eq4), .gt_o(gt4), .ne_o(ne4)
  );

  signed_sub_compare dut_w8 (
    .op_a(a8), .op_b(b8), .diff_o(d8),
    .lt_o(lt8), .eq_o(eq8), .gt_o(gt8), .ne_o(ne8)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(bit wide, logic [7:0] a, logic [7:0] b);
    exp_t e;
    int sa, sb;
    @(posedge clk);
    #1;
    if (wide) begin
      a8 = a; b8 = b;
      sa = int'($signed(a)); sb = int'($signed(b));
      e.diff = 8'(sa - sb);
    end else begin
      a4 = a[3:0]; b4 = b[3:0];
      sa = int'($signed(a[3:0])); sb = int'($signed(b[3:0]));
      e.diff = {4'h0, 4'(sa - sb)};
    end
    e.wide = wide;
    e.lt   = (sa < sb);
    e.eq   = (sa == sb);
    e.gt   = (sa > sb);
    e.ne   = (sa != sb);
    sb_q.push_back(e);
  endtask

  // monitor: compare half a cycle after each drive
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [7:0] ad;
      logic al, ae, ag, an, onehot;
      e = sb_q.pop_front();
      if (e.wide) begin
        ad = d8; al = lt8; ae = eq8; ag = gt8; an = ne8;
      end else begin
        ad = {4'h0, d4}; al = lt4; ae = eq4; ag = gt4; an = ne4;
      end
      onehot = ((al + ae + ag) == 1);
      check(e.wide ? "R7/R1" : "R1", "diff", ad, e.diff);
      check(e.wide ? "R7/R2" : "R2", "lt", {7'b0, al}, {7'b0, e.lt});
      check("R3", "eq", {7'b0, ae}, {7'b0, e.eq});
      check(e.wide ? "R7/R4" : "R4", "gt", {7'b0, ag}, {7'b0, e.gt});
      check("R5", "ne", {7'b0, an}, {7'b0, e.ne});
      check("R6", "onehot", {7'b0, onehot}, 8'h01);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time check: zero operands compare equal
    #1;
    check("R3", "initial eq", {7'b0, eq4}, 8'h01);
    // exhaustive sweep at 4 bits (covers overflow pairs for R2)
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        drive(1'b0, 8'(i), 8'(j));
      end
    end
    // R7 corners at the default width
    drive(1'b1, 8'h80, 8'h01);
    drive(1'b1, 8'h7F, 8'h80);
    drive(1'b1, 8'h80, 8'h7F);
    drive(1'b1, 8'h00, 8'h00);
    drive(1'b1, 8'hFF, 8'h01);
    drive(1'b1, 8'h01, 8'hFF);
    drive(1'b1, 8'h80, 8'h80);
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule